// File: doc/BRIEF.md
# Receive FIFO status tracker

This block keeps the status of a byte-wide receive FIFO that sits between a character receiver and a host. Each finished character, with its break, framing and parity marks, enters a one-entry holding slot. From there it is written into the FIFO storage in the first cycle the FIFO has room. The block keeps the FIFO occupancy itself and counts committed writes and effective host pops. It tells the storage when to write through a write strobe that carries the character and its marks.

Three status flags come out of the block:
- **Overrun.** This flag is sticky. It is raised when a character arrives while the holding slot is still occupied and the FIFO is at true capacity. The waiting character and its marks are then lost, and the newcomer takes the slot.
- **Almost-full.** This flag has hysteresis. It is raised when a commit lifts the occupancy above an alarm level, and it is dropped only once the occupancy falls to a release level.
- **Data-ready.** This flag is high whenever the FIFO holds at least one byte.

The receive side is a valid-only stream with no back-pressure: a character cannot be held off, so a character that finds no room is handled by the overrun rule. The write side to the storage is also valid-only. The storage never needs to refuse a write, because the block issues a write strobe only when its own count shows a free location.

Top module: `rxq_status_tracker`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: `fill_level`, `data_ready`, `ovr_flag`, `afull_flag` and `wr_valid`.
- R2: `data_ready` is high exactly when `fill_level` is non-zero.
- R3: A pop request while `fill_level` is zero is ignored, and the occupancy stays zero.
- R4: In a cycle with a pop request, the pop frees its location before the write decision is made. A full FIFO with a pending character and a pop therefore commits that character, keeps `fill_level` at capacity and raises no overrun.
- R5: A character presented with `in_valid` is written out on `wr_data`, `wr_brk`, `wr_frm` and `wr_par` with `wr_valid` high in the next cycle, when the FIFO has room in that cycle.
- R6: A character that finds the FIFO full waits in the holding slot. It is committed in the first cycle that has room.
- R7: An `in_valid` while the holding slot is occupied and the FIFO has no room raises `ovr_flag` in the next cycle. The waiting character and its three marks are discarded, and the new character takes the slot.
- R8: `ovr_flag` is sticky. Only `clr_err` clears it, and a new overrun in the same cycle as `clr_err` keeps it set.
- R9: Full means `fill_level` equals the capacity. The alarm level has no effect on overrun.
- R10: `afull_flag` rises in the cycle after a commit that leaves the occupancy greater than `alarm_lvl`.
- R11: Once set, `afull_flag` stays high until the occupancy is at or below `release_lvl`, and clears in that same cycle.
- R12: `fill_level` equals committed writes minus effective pops, and it never exceeds the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A finished character is presented this cycle |
| in_data | input | DW | Character value |
| in_brk | input | 1 | Break mark of the character |
| in_frm | input | 1 | Framing-error mark of the character |
| in_par | input | 1 | Parity-error mark of the character |
| pop_req | input | 1 | Host removes one byte (ignored when empty) |
| alarm_lvl | input | CW | Almost-full set level |
| release_lvl | input | CW | Almost-full release level |
| clr_err | input | 1 | Clear-errors command strobe |
| wr_valid | output | 1 | Write the held character into the FIFO storage |
| wr_data | output | DW | Character to write |
| wr_brk | output | 1 | Break mark to write |
| wr_frm | output | 1 | Framing mark to write |
| wr_par | output | 1 | Parity mark to write |
| fill_level | output | CW | Current occupancy |
| data_ready | output | 1 | FIFO not empty |
| ovr_flag | output | 1 | Sticky overrun |
| afull_flag | output | 1 | Almost-full with hysteresis |

## Verification
The bench builds the block with DEPTH set to 4 and DW set to 8, which gives a 3-bit count. With this setting the FIFO reaches true capacity in four commits, so every alarm and release pair from 0 to 4 can be swept through a full fill and a full drain. In the same setting the stalled holding slot, overrun, pop-first ordering and pops on an empty FIFO are each reached within a few cycles. A long pseudo-random stretch then mixes arrivals, pops, clears and level changes against an arithmetic model of the occupancy and the flags.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_marks_t;
endpackage

// File: rtl/rxq_hold_stage.sv
module rxq_hold_stage
  import rxq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  rxq_marks_t    in_marks,
  input  logic          space,
  input  logic          clr_err,
  output logic          hold_v,
  output logic [DW-1:0] hold_data,
  output rxq_marks_t    hold_marks,
  output logic          wr_valid,
  output logic          ovr_flag
);
  logic ovr_event;

  assign wr_valid  = hold_v & space;
  assign ovr_event = in_valid & hold_v & ~space;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v     <= 1'b0;
      hold_data  <= '0;
      hold_marks <= '0;
    end else if (in_valid) begin
      hold_v     <= 1'b1;
      hold_data  <= in_data;
      hold_marks <= in_marks;
    end else if (wr_valid) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ovr_flag <= 1'b0;
    else if (ovr_event) ovr_flag <= 1'b1;
    else if (clr_err)   ovr_flag <= 1'b0;
  end

  assert_overrun_replace_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hold_v && !space) |=> (ovr_flag && hold_v && hold_data == $past(in_data)));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !clr_err) |=> ovr_flag);
endmodule

// File: rtl/rxq_occupancy.sv
module rxq_occupancy #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop_req,
  input  logic          wr_valid,
  output logic          space,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] fill_next
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic          pop_eff;
  logic [CW-1:0] after_pop;

  assign pop_eff   = pop_req & (fill != '0);
  assign after_pop = fill - CW'(pop_eff);
  assign space     = after_pop < CAP;
  assign fill_next = after_pop + CW'(wr_valid);

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else     fill <= fill_next;
  end

  assert_fill_bound_R12: assert property (@(posedge clk) disable iff (rst)
    fill <= CAP);

  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && !wr_valid) |=> fill == '0);
endmodule

// File: rtl/rxq_alarm.sv
module rxq_alarm #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [CW-1:0] fill_next,
  input  logic [CW-1:0] alarm_lvl,
  input  logic [CW-1:0] release_lvl,
  output logic          afull
);
  logic set_hit;
  logic release_hit;

  assign set_hit     = wr_valid & (fill_next > alarm_lvl);
  assign release_hit = fill_next <= release_lvl;

  always_ff @(posedge clk) begin
    if (rst)              afull <= 1'b0;
    else if (set_hit)     afull <= 1'b1;
    else if (release_hit) afull <= 1'b0;
  end

  assert_afull_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(afull) |-> $past(wr_valid));

  assert_afull_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (afull && fill_next > release_lvl) |=> afull);
endmodule

// File: rtl/rxq_status_tracker.sv
module rxq_status_tracker
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_brk,
  input  logic          in_frm,
  input  logic          in_par,
  input  logic          pop_req,
  input  logic [CW-1:0] alarm_lvl,
  input  logic [CW-1:0] release_lvl,
  input  logic          clr_err,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          wr_brk,
  output logic          wr_frm,
  output logic          wr_par,
  output logic [CW-1:0] fill_level,
  output logic          data_ready,
  output logic          ovr_flag,
  output logic          afull_flag
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  rxq_marks_t    in_marks;
  rxq_marks_t    hold_marks;
  logic          hold_v;
  logic          space;
  logic [CW-1:0] fill_next;

  assign in_marks = '{brk: in_brk, frm: in_frm, par: in_par};

  rxq_hold_stage #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_marks  (in_marks),
    .space     (space),
    .clr_err   (clr_err),
    .hold_v    (hold_v),
    .hold_data (wr_data),
    .hold_marks(hold_marks),
    .wr_valid  (wr_valid),
    .ovr_flag  (ovr_flag)
  );

  rxq_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk      (clk),
    .rst      (rst),
    .pop_req  (pop_req),
    .wr_valid (wr_valid),
    .space    (space),
    .fill     (fill_level),
    .fill_next(fill_next)
  );

  rxq_alarm #(.CW(CW)) u_alarm (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .fill_next  (fill_next),
    .alarm_lvl  (alarm_lvl),
    .release_lvl(release_lvl),
    .afull      (afull_flag)
  );

  assign wr_brk     = hold_marks.brk;
  assign wr_frm     = hold_marks.frm;
  assign wr_par     = hold_marks.par;
  assign data_ready = fill_level != '0;

  assert_pop_first_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_level == CAP && hold_v && pop_req) |-> wr_valid);

  assert_full_only_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fill_level < CAP) |=> !$rose(ovr_flag));
endmodule

// File: tb/rxq_status_tracker_bench.sv
`timescale 1ns/1ps
module rxq_status_tracker_bench;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, in_valid, in_brk, in_frm, in_par, pop_req, clr_err;
  logic [DW-1:0] in_data;
  logic [CW-1:0] alarm_lvl, release_lvl;
  logic wr_valid, wr_brk, wr_frm, wr_par, data_ready, ovr_flag, afull_flag;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] fill_level;

  rxq_status_tracker #(.DW(DW), .DEPTH(DEPTH)) u_rxq_status_tracker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_brk(in_brk), .in_frm(in_frm), .in_par(in_par), .pop_req(pop_req),
    .alarm_lvl(alarm_lvl), .release_lvl(release_lvl), .clr_err(clr_err),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_brk(wr_brk), .wr_frm(wr_frm),
    .wr_par(wr_par), .fill_level(fill_level), .data_ready(data_ready),
    .ovr_flag(ovr_flag), .afull_flag(afull_flag));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int m_cnt, al, rl;
  bit m_hv, m_ovr, m_af;
  logic [7:0] m_hd;
  logic [2:0] m_hf;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_levels(input int a, input int r);
    al = a; rl = r;
    alarm_lvl = CW'(a); release_lvl = CW'(r);
  endtask

  task automatic step(input bit v, input logic [7:0] d, input logic [2:0] f,
                      input bit pop, input bit clr);
    int pe, cap, nx;
    bit sp, wr, ev;
    in_valid = v; in_data = d; in_brk = f[2]; in_frm = f[1]; in_par = f[0];
    pop_req = pop; clr_err = clr;
    #1;
    pe  = (pop && m_cnt > 0) ? 1 : 0;
    cap = m_cnt - pe;
    sp  = cap < DEPTH;
    wr  = m_hv && sp;
    ev  = v && m_hv && !sp;
    chk("R5 R6 commit strobe", wr_valid, wr);
    if (wr) begin
      chk("R5 committed data", wr_data, m_hd);
      chk("R5 R7 committed marks", {wr_brk, wr_frm, wr_par}, m_hf);
    end
    nx = cap + (wr ? 1 : 0);
    if (wr && nx > al) m_af = 1;
    else if (nx <= rl) m_af = 0;
    if (ev) m_ovr = 1;
    else if (clr) m_ovr = 0;
    if (v) begin m_hv = 1; m_hd = d; m_hf = f; end
    else if (wr) m_hv = 0;
    m_cnt = nx;
    @(posedge clk); #1;
    in_valid = 0; pop_req = 0; clr_err = 0;
    chk("R12 occupancy", fill_level, m_cnt);
    chk("R2 data ready", data_ready, m_cnt != 0);
    chk("R7 R8 overrun", ovr_flag, m_ovr);
    chk("R10 R11 almost full", afull_flag, m_af);
  endtask

  task automatic drain();
    while (m_cnt > 0 || m_hv) step(0, 8'h00, 3'b000, 1, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst = 1; in_valid = 0; in_data = '0; in_brk = 0; in_frm = 0; in_par = 0;
    pop_req = 0; clr_err = 0;
    set_levels(2, 1);
    m_cnt = 0; m_hv = 0; m_ovr = 0; m_af = 0; m_hd = '0; m_hf = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    chk("R1 reset occupancy", fill_level, 0);
    chk("R1 reset ready", data_ready, 0);
    chk("R1 reset overrun", ovr_flag, 0);
    chk("R1 reset almost full", afull_flag, 0);
    chk("R1 reset strobe", wr_valid, 0);
    @(posedge clk); #1;

    // Level sweep: every alarm/release pair through fill, stall and drain
    for (int a = 0; a <= DEPTH; a++) begin
      for (int r = 0; r <= DEPTH; r++) begin
        set_levels(a, r);
        step(0, 8'h00, 3'b000, 0, 1);
        for (int i = 0; i < DEPTH; i++)
          step(1, 8'(a * 40 + r * 8 + i), 3'(i + a), 0, 0);
        step(0, 8'h00, 3'b000, 0, 0);
        step(1, 8'(200 + a + r), 3'(r), 0, 0);
        step(0, 8'h00, 3'b000, 0, 0);
        chk("R6 waiting at capacity", fill_level, DEPTH);
        repeat (DEPTH + 3) step(0, 8'h00, 3'b000, 1, 0);
        chk("R3 pop on empty", fill_level, 0);
      end
    end

    // R9: alarm at zero, back-to-back arrivals below capacity
    set_levels(0, 0);
    step(0, 8'h00, 3'b000, 0, 1);
    for (int i = 0; i < DEPTH; i++) step(1, 8'(16 + i), 3'(i), 0, 0);
    chk("R9 no overrun below capacity", ovr_flag, 0);
    step(1, 8'h55, 3'b101, 0, 0);
    step(1, 8'hA6, 3'b011, 0, 0);
    chk("R7 overrun at capacity", ovr_flag, 1);
    step(0, 8'h00, 3'b000, 0, 0);
    chk("R8 sticky overrun", ovr_flag, 1);
    step(1, 8'h3C, 3'b110, 0, 1);
    chk("R8 new overrun beats clear", ovr_flag, 1);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R8 clear", ovr_flag, 0);
    // R4: full with a pending character, pop and arrival together
    step(1, 8'h77, 3'b001, 1, 0);
    chk("R4 stays at capacity", fill_level, DEPTH);
    chk("R4 no overrun", ovr_flag, 0);
    drain();

    // Pseudo-random mix
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (n % 97 == 0) set_levels(lf[2:0] % (DEPTH + 1), lf[6:4] % (DEPTH + 1));
      step(lf[0] | lf[9], lf[15:8], lf[5:3], lf[1] & lf[7], lf[11:8] == 4'h0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule